// File: doc/BRIEF.md
# Free-Buffer Hysteresis Pause Generator

This block keeps a running count of free blocks in a shared receive buffer pool and turns that count into two flow-control request levels for a single interface: a high-priority pause and a low-priority pause. Each level has its own assert threshold and its own release threshold. The gap between the two thresholds gives hysteresis, so a count that wanders near one threshold does not make the pause level toggle.

Single-cycle allocate and release pulses move the free count down and up. A small write-only register port loads the four thresholds and can overwrite the free count at any time. The block reports the number of occupied blocks as the pool size minus the free count. It does not manage the buffer memory, it does not keep the block lists, and it does not build pause frames.

Top module: `fbuf_pause_gen`

## Requirements
- R1: After reset both pause outputs are 0, the free count equals the parameter INIT_FREE, and `fullBlocks` equals POOL_SIZE minus INIT_FREE. The threshold registers reset to their parameter values.
- R2: An allocate pulse without a release pulse lowers the free count by one, and `fullBlocks` shows this after the clock edge that samples the pulse. A release pulse without an allocate pulse raises the free count by one in the same way.
- R3: An allocate pulse and a release pulse in the same cycle leave the free count unchanged.
- R4: The free count stops at 0 when an allocate pulse arrives and stops at POOL_SIZE when a release pulse arrives, so `fullBlocks` always stays between 0 and POOL_SIZE.
- R5: A write to address 4 loads the free count from `cfgWdata`. A value above POOL_SIZE is clamped to POOL_SIZE. This load has priority over any allocate or release pulse in the same cycle.
- R6: `hiPause` becomes 1 on the clock edge after the free count is strictly below the high-priority assert threshold. That threshold is written at address 0.
- R7: `hiPause` becomes 0 on the clock edge after the free count is strictly above the high-priority release threshold. That threshold is written at address 1.
- R8: When the free count lies between the two thresholds of a level, with either threshold included, that pause level keeps its previous value. A count equal to a threshold therefore changes nothing.
- R9: `loPause` follows the same rules as `hiPause`, using its own assert threshold at address 2 and its own release threshold at address 3, independently of `hiPause`.
- R10: If the assert threshold is set above the release threshold and the free count meets both conditions, the level asserts.
- R11: Writes to addresses 5, 6 and 7 have no effect on the thresholds, on the free count or on any output.
- R12: A threshold write takes effect for the comparison made at the next clock edge. The edge that samples the write still compares against the old threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocPulse | input | 1 | One free block taken this cycle |
| releasePulse | input | 1 | One block returned this cycle |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address (0 to 4 used) |
| cfgWdata | input | 10 | Register write data |
| hiPause | output | 1 | High-priority pause request level |
| loPause | output | 1 | Low-priority pause request level |
| fullBlocks | output | 24 | Number of occupied blocks |

## Verification
The bench aims at counts exactly equal to each threshold. A design that used a non-strict comparison would toggle a pause level there. It drains the pool to zero and fills it to POOL_SIZE with extra pulses; a missing saturation shows up as a wrapped `fullBlocks`. It also sends simultaneous allocate and release pulses, which a design with a priority instead of a cancel would count as a step. Further directed cases cover a load that collides with pulses, an oversized load value, crossed thresholds, and writes to unused addresses. These run alongside a seeded random mix of pulses and register writes, checked every cycle against a cycle-exact model.

// File: rtl/fbpg_pkg.sv
package fbpg_pkg;

  localparam int FB_CNT_W  = 10;
  localparam int FB_NUM_CH = 2;
  localparam int FB_ADDR_W = 3;

  localparam logic [FB_ADDR_W-1:0] ADDR_FREE = 3'd4;

  typedef struct packed {
    logic                inc;
    logic                dec;
    logic                ldFree;
    logic [FB_CNT_W-1:0] freeVal;
  } fbStrobe_t;

  typedef struct packed {
    logic [FB_CNT_W-1:0] asrt;
    logic [FB_CNT_W-1:0] rel;
  } fbThr_t;

endpackage

// File: rtl/fbpg_ctrl.sv
module fbpg_ctrl
  import fbpg_pkg::*;
#(
  parameter int POOL_SIZE   = 1000,
  parameter int HI_ASRT_RST = 100,
  parameter int HI_REL_RST  = 200,
  parameter int LO_ASRT_RST = 300,
  parameter int LO_REL_RST  = 400
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            allocPulse,
  input  logic                            releasePulse,
  input  logic                            cfgWe,
  input  logic [FB_ADDR_W-1:0]            cfgAddr,
  input  logic [FB_CNT_W-1:0]             cfgWdata,
  output fbStrobe_t                       strobe,
  output fbThr_t [FB_NUM_CH-1:0]          thr
);

  localparam logic [FB_CNT_W-1:0] POOL_V = FB_CNT_W'(POOL_SIZE);

  function automatic fbThr_t rstThr(input int ch);
    fbThr_t t;
    if (ch == 0) begin
      t.asrt = FB_CNT_W'(HI_ASRT_RST);
      t.rel  = FB_CNT_W'(HI_REL_RST);
    end else begin
      t.asrt = FB_CNT_W'(LO_ASRT_RST);
      t.rel  = FB_CNT_W'(LO_REL_RST);
    end
    return t;
  endfunction

  fbThr_t thrQ [FB_NUM_CH];

  // Channel ch owns address 2*ch (assert) and 2*ch+1 (release).
  for (genvar ch = 0; ch < FB_NUM_CH; ch++) begin : g_thr
    localparam logic [FB_ADDR_W-1:0] A_ASRT = FB_ADDR_W'(2 * ch);
    localparam logic [FB_ADDR_W-1:0] A_REL  = FB_ADDR_W'(2 * ch + 1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        thrQ[ch] <= rstThr(ch);
      end else if (cfgWe) begin
        if (cfgAddr == A_ASRT) thrQ[ch].asrt <= cfgWdata;
        if (cfgAddr == A_REL)  thrQ[ch].rel  <= cfgWdata;
      end
    end

    assign thr[ch] = thrQ[ch];
  end

  logic loadHit;

  always_comb begin
    loadHit        = cfgWe && (cfgAddr == ADDR_FREE);
    strobe.ldFree  = loadHit;
    strobe.freeVal = (cfgWdata > POOL_V) ? POOL_V : cfgWdata;
    strobe.inc     = releasePulse && !allocPulse && !loadHit;
    strobe.dec     = allocPulse && !releasePulse && !loadHit;
  end

endmodule

// File: rtl/fbpg_hyst.sv
module fbpg_hyst
  import fbpg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [FB_CNT_W-1:0] level,
  input  logic [FB_CNT_W-1:0] asrtThr,
  input  logic [FB_CNT_W-1:0] relThr,
  output logic                pause
);

  logic pauseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pauseQ <= 1'b0;
    end else if (level < asrtThr) begin
      pauseQ <= 1'b1;
    end else if (level > relThr) begin
      pauseQ <= 1'b0;
    end
  end

  assign pause = pauseQ;

endmodule

// File: rtl/fbpg_datapath.sv
module fbpg_datapath
  import fbpg_pkg::*;
#(
  parameter int POOL_SIZE = 1000,
  parameter int INIT_FREE = 1000,
  parameter int FULL_W    = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fbStrobe_t              strobe,
  input  fbThr_t [FB_NUM_CH-1:0] thr,
  output logic [FB_CNT_W-1:0]    freeCnt,
  output logic [FB_NUM_CH-1:0]   pause,
  output logic [FULL_W-1:0]      fullBlocks
);

  localparam logic [FB_CNT_W-1:0] POOL_V = FB_CNT_W'(POOL_SIZE);
  localparam logic [FB_CNT_W-1:0] INIT_V = FB_CNT_W'(INIT_FREE);

  logic [FB_CNT_W-1:0] freeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeQ <= INIT_V;
    end else if (strobe.ldFree) begin
      freeQ <= strobe.freeVal;
    end else if (strobe.inc && (freeQ != POOL_V)) begin
      freeQ <= freeQ + 1'b1;
    end else if (strobe.dec && (freeQ != '0)) begin
      freeQ <= freeQ - 1'b1;
    end
  end

  assign freeCnt    = freeQ;
  assign fullBlocks = FULL_W'(POOL_SIZE) - FULL_W'(freeQ);

  for (genvar ch = 0; ch < FB_NUM_CH; ch++) begin : g_ch
    fbpg_hyst u_hyst (
      .clk    (clk),
      .rstN   (rstN),
      .level  (freeQ),
      .asrtThr(thr[ch].asrt),
      .relThr (thr[ch].rel),
      .pause  (pause[ch])
    );
  end

endmodule

// File: rtl/fbuf_pause_gen.sv
module fbuf_pause_gen
  import fbpg_pkg::*;
#(
  parameter int POOL_SIZE   = 1000,
  parameter int INIT_FREE   = 1000,
  parameter int FULL_W      = 24,
  parameter int HI_ASRT_RST = 100,
  parameter int HI_REL_RST  = 200,
  parameter int LO_ASRT_RST = 300,
  parameter int LO_REL_RST  = 400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocPulse,
  input  logic                 releasePulse,
  input  logic                 cfgWe,
  input  logic [2:0]           cfgAddr,
  input  logic [9:0]           cfgWdata,
  output logic                 hiPause,
  output logic                 loPause,
  output logic [FULL_W-1:0]    fullBlocks
);

  fbStrobe_t                strobe;
  fbThr_t [FB_NUM_CH-1:0]   thrBus;
  logic [FB_CNT_W-1:0]      freeCnt;
  logic [FB_NUM_CH-1:0]     pauseVec;

  fbpg_ctrl #(
    .POOL_SIZE  (POOL_SIZE),
    .HI_ASRT_RST(HI_ASRT_RST),
    .HI_REL_RST (HI_REL_RST),
    .LO_ASRT_RST(LO_ASRT_RST),
    .LO_REL_RST (LO_REL_RST)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .allocPulse  (allocPulse),
    .releasePulse(releasePulse),
    .cfgWe       (cfgWe),
    .cfgAddr     (cfgAddr),
    .cfgWdata    (cfgWdata),
    .strobe      (strobe),
    .thr         (thrBus)
  );

  fbpg_datapath #(
    .POOL_SIZE(POOL_SIZE),
    .INIT_FREE(INIT_FREE),
    .FULL_W   (FULL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .thr       (thrBus),
    .freeCnt   (freeCnt),
    .pause     (pauseVec),
    .fullBlocks(fullBlocks)
  );

  assign hiPause = pauseVec[0];
  assign loPause = pauseVec[1];

endmodule

// File: rtl/fbpg_checker.sv
module fbpg_checker
  import fbpg_pkg::*;
#(
  parameter int POOL_SIZE = 1000,
  parameter int FULL_W    = 24
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   allocPulse,
  input logic                   releasePulse,
  input logic                   cfgWe,
  input logic [2:0]             cfgAddr,
  input logic [FB_CNT_W-1:0]    freeCnt,
  input fbThr_t [FB_NUM_CH-1:0] thrBus,
  input logic                   hiPause,
  input logic                   loPause,
  input logic [FULL_W-1:0]      fullBlocks
);

  logic loadNow;
  assign loadNow = cfgWe && (cfgAddr == ADDR_FREE);

  a_r2_alloc_step: assert property (@(posedge clk) disable iff (!rstN)
    (allocPulse && !releasePulse && !loadNow && (fullBlocks < FULL_W'(POOL_SIZE)))
      |=> (fullBlocks == $past(fullBlocks) + 1'b1));

  a_r3_both_hold: assert property (@(posedge clk) disable iff (!rstN)
    (allocPulse && releasePulse && !loadNow) |=> $stable(fullBlocks));

  a_r4_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fullBlocks <= FULL_W'(POOL_SIZE));

  a_r6_hi_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiPause) |-> ($past(freeCnt) < $past(thrBus[0].asrt)));

  a_r7_hi_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hiPause) |-> ($past(freeCnt) > $past(thrBus[0].rel)));

  a_r8_hi_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((freeCnt >= thrBus[0].asrt) && (freeCnt <= thrBus[0].rel)) |=> $stable(hiPause));

  a_r9_lo_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loPause) |-> ($past(freeCnt) < $past(thrBus[1].asrt)));

  a_r9_lo_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loPause) |-> ($past(freeCnt) > $past(thrBus[1].rel)));

endmodule

bind fbuf_pause_gen fbpg_checker #(
  .POOL_SIZE(POOL_SIZE),
  .FULL_W   (FULL_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .allocPulse  (allocPulse),
  .releasePulse(releasePulse),
  .cfgWe       (cfgWe),
  .cfgAddr     (cfgAddr),
  .freeCnt     (freeCnt),
  .thrBus      (thrBus),
  .hiPause     (hiPause),
  .loPause     (loPause),
  .fullBlocks  (fullBlocks)
);

// File: tb/fbuf_pause_gen_bench.sv
module fbuf_pause_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int POOL       = 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocPulse = 1'b0;
  logic        releasePulse = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [9:0]  cfgWdata = '0;
  logic        hiPause;
  logic        loPause;
  logic [23:0] fullBlocks;

  int testCnt = 0;
  int failCnt = 0;

  int freeM;
  int thrM [4];
  bit hiM;
  bit loM;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fbuf_pause_gen u_fbuf_pause_gen (
    .clk         (clk),
    .rstN        (rstN),
    .allocPulse  (allocPulse),
    .releasePulse(releasePulse),
    .cfgWe       (cfgWe),
    .cfgAddr     (cfgAddr),
    .cfgWdata    (cfgWdata),
    .hiPause     (hiPause),
    .loPause     (loPause),
    .fullBlocks  (fullBlocks)
  );

  function automatic bit nextPause(bit cur, int lvl, int asrt, int rel);
    if (lvl < asrt) return 1'b1;
    if (lvl > rel)  return 1'b0;
    return cur;
  endfunction

  function automatic int nextFree(int f, bit a, bit r, bit we, int addr, int d);
    if (we && addr == 4) return (d > POOL) ? POOL : d;
    if (a && !r) return (f > 0) ? f - 1 : 0;
    if (r && !a) return (f < POOL) ? f + 1 : POOL;
    return f;
  endfunction

  task automatic checkAll(string tag);
    testCnt++;
    if (hiPause !== hiM) begin
      failCnt++;
      $display("FAIL %s hiPause actual %0b expected %0b", tag, hiPause, hiM);
    end
    testCnt++;
    if (loPause !== loM) begin
      failCnt++;
      $display("FAIL %s loPause actual %0b expected %0b", tag, loPause, loM);
    end
    testCnt++;
    if (fullBlocks !== 24'(POOL - freeM)) begin
      failCnt++;
      $display("FAIL %s fullBlocks actual %0d expected %0d", tag, fullBlocks, POOL - freeM);
    end
  endtask

  // Called at a falling edge; drives, clocks once, updates model, checks.
  task automatic step(bit a, bit r, bit we, int addr, int d, string tag);
    bit hiN;
    bit loN;
    allocPulse   = a;
    releasePulse = r;
    cfgWe        = we;
    cfgAddr      = 3'(addr);
    cfgWdata     = 10'(d);
    @(posedge clk);
    hiN = nextPause(hiM, freeM, thrM[0], thrM[1]);
    loN = nextPause(loM, freeM, thrM[2], thrM[3]);
    if (we && addr < 4) thrM[addr] = d;
    freeM = nextFree(freeM, a, r, we, addr, d);
    hiM = hiN;
    loM = loN;
    @(negedge clk);
    allocPulse = 1'b0; releasePulse = 1'b0; cfgWe = 1'b0;
    checkAll(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    freeM = POOL;
    thrM[0] = 100; thrM[1] = 200; thrM[2] = 300; thrM[3] = 400;
    hiM = 0; loM = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");

    // R5: load, with pulses in the same cycle ignored
    step(1, 0, 1, 4, 150, "R5");
    idle(2, "R9");
    step(0, 1, 1, 4, 1023, "R5");
    idle(2, "R9");

    // R6/R8: walk down to hi assert threshold
    step(0, 0, 1, 4, 101, "R6");
    step(1, 0, 0, 0, 0, "R8");
    idle(2, "R8");
    step(1, 0, 0, 0, 0, "R6");
    idle(2, "R6");
    // R7/R8: walk up through release threshold
    step(0, 0, 1, 4, 199, "R7");
    step(0, 1, 0, 0, 0, "R8");
    idle(2, "R8");
    step(0, 1, 0, 0, 0, "R7");
    idle(2, "R7");

    // R3: simultaneous pulses
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0, "R3");

    // R4: drain past zero, fill past the pool size
    step(0, 0, 1, 4, 2, "R4");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 4, 997, "R4");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0, "R4");

    // R9: lo thresholds move independently
    step(0, 0, 1, 2, 900, "R12");
    step(0, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 3, 950, "R9");
    idle(2, "R9");
    step(0, 0, 1, 2, 10, "R9");
    idle(2, "R9");

    // R10: crossed thresholds, assert wins
    step(0, 0, 1, 0, 500, "R10");
    step(0, 0, 1, 1, 50, "R10");
    step(0, 0, 1, 4, 300, "R10");
    idle(3, "R10");

    // R11: unused addresses
    for (int ad = 5; ad < 8; ad++) step(0, 0, 1, ad, 7, "R11");
    idle(2, "R11");

    // restore sane thresholds
    step(0, 0, 1, 0, 100, "R12");
    step(0, 0, 1, 1, 200, "R12");
    step(0, 0, 1, 2, 300, "R12");
    step(0, 0, 1, 3, 400, "R12");

    // R2 and mixed: seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned rnd = $urandom;
      bit a  = (rnd[3:0] < 6);
      bit r  = (rnd[7:4] < 6);
      bit we = (rnd[15:8] < 4);
      int ad = int'(rnd[18:16]);
      int dv = (ad == 4) ? int'(rnd[31:22]) % 600 : int'(rnd[31:22]);
      if (we && ad < 4) dv = int'(rnd[31:22]) % 600;
      step(a, r, we, ad, dv, "R2");
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule